// File: doc/BRIEF.md
# Supervisor access control register unit

This unit keeps the paging-control bits of a processor's fourth control register together with the alignment-check flag, and from them and the current privilege level it derives which memory-access privilege mode the address-translation logic must use. Software updates the control register through a plain write strobe. The unit cleans the written value of bits whose feature is not provided. It keeps two shadow flags for the rest of the core, and it requests a TLB flush whenever a protection-relevant bit changes.

Two instructions clear and set the alignment-check flag. The decoder forwards them as one-cycle strobes. The unit accepts them only at privilege level 0 and only when the user-access-prevention feature is provided. Otherwise it reports an illegal opcode and leaves the flag alone. The mode index has three values: user mode, kernel mode, and kernel mode in which the alignment-check flag permits access to user pages. All interfaces are plain control strobes and levels. Nothing streams through the unit, so there is no valid/ready handshake and no back-pressure.

Top module: `sup_access_ctl`

## Requirements
- R1: After a synchronous reset the register value, the alignment-check flag, both shadow flags, the flush request and the illegal-opcode output are all 0. With privilege level 0 the mode index is then 0.
- R2: A write strobe stores the written value at the next clock edge. Every bit other than bit 21 and bit 9 is stored exactly as written, reserved bits included.
- R3: Bit 21 (user-access prevention enable) is stored as 0 when `feat_uap` is low. Bit 9 (extended FP state enable) is stored as 0 when `feat_sse` is low.
- R4: `tlb_flush` is high for exactly the one cycle after a write, and only when the raw written value differs from the stored value in bit 4, 5, 7, 20 or 21. The raw value is the one before the cleaning of R3.
- R5: After each write, `uap_active` equals stored bit 21 and `fxsr_active` equals stored bit 9.
- R6: At privilege level 0 with `feat_uap` high, a clear strobe alone makes `ac_flag` 0 and a set strobe alone makes it 1, from the next edge.
- R7: A clear or set strobe at a privilege level other than 0, or with `feat_uap` low, raises `illegal_op` for the one cycle after the strobe and leaves `ac_flag` unchanged.
- R8: Clear and set strobes in the same cycle are illegal: `illegal_op` pulses and `ac_flag` is unchanged.
- R9: `mode_idx` is 1 when `cpl` is 3. Otherwise it is 2 when `uap_active` and `ac_flag` are both 1. Otherwise it is 0. It follows `cpl` combinationally.
- R10: A write and a legal clear or set strobe in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| feat_sse | input | 1 | Extended FP state feature provided |
| feat_uap | input | 1 | User-access-prevention feature provided |
| cpl | input | 2 | Current privilege level |
| cr_wr_en | input | 1 | Control register write strobe |
| cr_wr_data | input | 32 | Value written to the control register |
| ac_clr | input | 1 | Clear-alignment-check instruction strobe |
| ac_set | input | 1 | Set-alignment-check instruction strobe |
| cr_value | output | 32 | Stored control register value |
| ac_flag | output | 1 | Alignment-check flag |
| uap_active | output | 1 | Shadow of stored bit 21 |
| fxsr_active | output | 1 | Shadow of stored bit 9 |
| tlb_flush | output | 1 | One-cycle TLB flush request |
| illegal_op | output | 1 | One-cycle illegal-opcode report |
| mode_idx | output | 2 | Memory-access mode: 0 kernel, 1 user, 2 kernel with override |

## Verification
The embedded assertions check on every cycle that a flush appears only after a write, that bit 21 never survives a write made without the feature, that the flag stays put across an illegal strobe, and that the mode index obeys its user and override conditions. The bench sweeps every combination of privilege level, feature input and strobe pattern, every single-bit toggle of the register under all feature settings, and every mode input combination. Only these scenarios can show that the right bits trigger the flush, that reserved bits pass through unchanged, and that simultaneous writes and flag updates both land.

// File: rtl/sacu_pkg.sv
package sacu_pkg;
  localparam int CR_W       = 32;
  localparam int BIT_PSE    = 4;
  localparam int BIT_PAE    = 5;
  localparam int BIT_PGE    = 7;
  localparam int BIT_FXSR   = 9;
  localparam int BIT_SUPX   = 20;
  localparam int BIT_UAP    = 21;

  typedef enum logic [1:0] {
    MODE_KERNEL   = 2'd0,
    MODE_USER     = 2'd1,
    MODE_KOVERRIDE = 2'd2
  } mode_e;

  function automatic logic [CR_W-1:0] bitmask(input int pos);
    logic [CR_W-1:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

  localparam logic [CR_W-1:0] FLUSH_MASK =
    bitmask(BIT_PSE) | bitmask(BIT_PAE) | bitmask(BIT_PGE) |
    bitmask(BIT_SUPX) | bitmask(BIT_UAP);
endpackage

// File: rtl/sacu_cr_file.sv
module sacu_cr_file
  import sacu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            feat_sse,
  input  logic            feat_uap,
  input  logic            wr_en,
  input  logic [CR_W-1:0] wr_data,
  output logic [CR_W-1:0] cr_q,
  output logic            uap_q,
  output logic            fxsr_q,
  output logic            flush_q
);
  logic [CR_W-1:0] clean;
  logic            changed;

  always_comb begin
    clean = wr_data;
    if (!feat_uap) clean[BIT_UAP]  = 1'b0;
    if (!feat_sse) clean[BIT_FXSR] = 1'b0;
  end

  assign changed = |((cr_q ^ wr_data) & FLUSH_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q    <= '0;
      uap_q   <= 1'b0;
      fxsr_q  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= wr_en && changed;
      if (wr_en) begin
        cr_q   <= clean;
        uap_q  <= clean[BIT_UAP];
        fxsr_q <= clean[BIT_FXSR];
      end
    end
  end

  p_flush_after_write_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> !flush_q);
  p_uap_gated_r3: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !feat_uap) |-> !cr_q[BIT_UAP]);
  p_shadow_match_r5: assert property (@(posedge clk) disable iff (rst)
    (uap_q == cr_q[BIT_UAP]) && (fxsr_q == cr_q[BIT_FXSR]));
endmodule

// File: rtl/sacu_ac_ctl.sv
module sacu_ac_ctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       feat_uap,
  input  logic [1:0] cpl,
  input  logic       clr_req,
  input  logic       set_req,
  output logic       ac_q,
  output logic       illegal_q
);
  logic any_req, permitted, legal;

  assign any_req   = clr_req || set_req;
  assign permitted = feat_uap && (cpl == 2'd0);
  assign legal     = permitted && (clr_req ^ set_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_q      <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= any_req && !legal;
      if (legal) ac_q <= set_req;
    end
  end

  p_ac_hold_on_illegal_r7: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> $stable(ac_q));
  p_no_change_without_req_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(clr_req || set_req) |-> $stable(ac_q));
endmodule

// File: rtl/sacu_mode_dec.sv
module sacu_mode_dec
  import sacu_pkg::*;
(
  input  logic [1:0] cpl,
  input  logic       uap_on,
  input  logic       ac,
  output logic [1:0] mode
);
  mode_e m;

  always_comb begin
    if (cpl == 2'd3)        m = MODE_USER;
    else if (uap_on && ac)  m = MODE_KOVERRIDE;
    else                    m = MODE_KERNEL;
  end

  assign mode = m;

  always_comb begin
    a_mode_user_r9: assert (!(cpl == 2'd3) || mode == 2'd1);
    a_mode_override_r9: assert (mode != 2'd2 || (uap_on && ac && cpl != 2'd3));
  end
endmodule

// File: rtl/sup_access_ctl.sv
module sup_access_ctl
  import sacu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            feat_sse,
  input  logic            feat_uap,
  input  logic [1:0]      cpl,
  input  logic            cr_wr_en,
  input  logic [CR_W-1:0] cr_wr_data,
  input  logic            ac_clr,
  input  logic            ac_set,
  output logic [CR_W-1:0] cr_value,
  output logic            ac_flag,
  output logic            uap_active,
  output logic            fxsr_active,
  output logic            tlb_flush,
  output logic            illegal_op,
  output logic [1:0]      mode_idx
);
  sacu_cr_file u_cr (
    .clk(clk), .rst(rst), .feat_sse(feat_sse), .feat_uap(feat_uap),
    .wr_en(cr_wr_en), .wr_data(cr_wr_data), .cr_q(cr_value),
    .uap_q(uap_active), .fxsr_q(fxsr_active), .flush_q(tlb_flush)
  );

  sacu_ac_ctl u_ac (
    .clk(clk), .rst(rst), .feat_uap(feat_uap), .cpl(cpl),
    .clr_req(ac_clr), .set_req(ac_set), .ac_q(ac_flag), .illegal_q(illegal_op)
  );

  sacu_mode_dec u_mode (
    .cpl(cpl), .uap_on(uap_active), .ac(ac_flag), .mode(mode_idx)
  );

  p_reset_clears_r1: assert property (@(posedge clk)
    $past(rst) |-> (cr_value == '0 && !ac_flag && !tlb_flush && !illegal_op));
endmodule

// File: tb/test_sup_access_ctl.sv
module test_sup_access_ctl;
  logic clk = 0, rst = 1;
  logic feat_sse = 0, feat_uap = 0;
  logic [1:0] cpl = 0;
  logic cr_wr_en = 0;
  logic [31:0] cr_wr_data = 0;
  logic ac_clr = 0, ac_set = 0;
  logic [31:0] cr_value;
  logic ac_flag, uap_active, fxsr_active, tlb_flush, illegal_op;
  logic [1:0] mode_idx;

  int checks = 0, failures = 0;
  logic [31:0] m_cr = 0;
  logic m_ac = 0;
  localparam logic [31:0] FMASK = (32'h1 << 4) | (32'h1 << 5) | (32'h1 << 7) |
                                  (32'h1 << 20) | (32'h1 << 21);

  always #5 clk = ~clk;

  sup_access_ctl i_sup_access_ctl (
    .clk(clk), .rst(rst), .feat_sse(feat_sse), .feat_uap(feat_uap), .cpl(cpl),
    .cr_wr_en(cr_wr_en), .cr_wr_data(cr_wr_data), .ac_clr(ac_clr), .ac_set(ac_set),
    .cr_value(cr_value), .ac_flag(ac_flag), .uap_active(uap_active),
    .fxsr_active(fxsr_active), .tlb_flush(tlb_flush), .illegal_op(illegal_op),
    .mode_idx(mode_idx)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, the posedge between captures, sample at next negedge
  task automatic step();
    @(negedge clk);
    cr_wr_en = 0; ac_clr = 0; ac_set = 0;
  endtask

  task automatic do_write(input logic [31:0] v, input bit fs, input bit fu);
    logic [31:0] clean;
    logic exp_fl;
    feat_sse = fs; feat_uap = fu;
    cr_wr_en = 1; cr_wr_data = v;
    clean = v;
    if (!fu) clean[21] = 0;
    if (!fs) clean[9] = 0;
    exp_fl = |((m_cr ^ v) & FMASK);
    step();
    m_cr = clean;
    chk(cr_value == clean, "R2/R3 stored value", cr_value, clean);
    chk(tlb_flush == exp_fl, "R4 flush request", tlb_flush, exp_fl);
    chk(uap_active == clean[21] && fxsr_active == clean[9], "R5 shadows",
        {uap_active, fxsr_active}, {clean[21], clean[9]});
    step();
    chk(!tlb_flush, "R4 flush one cycle", tlb_flush, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1
    chk(cr_value == 0 && !ac_flag && !uap_active && !fxsr_active, "R1 reset state",
        {cr_value[29:0], ac_flag, uap_active}, 0);
    chk(!tlb_flush && !illegal_op && mode_idx == 0, "R1 reset outputs",
        {tlb_flush, illegal_op, mode_idx}, 0);

    // R2 R3 R4 R5: every single-bit toggle under every feature setting
    for (int b = 0; b < 32; b++)
      for (int f = 0; f < 4; f++)
        do_write(m_cr ^ (32'h1 << b), f[0], f[1]);
    do_write(32'hFFFF_FFFF, 0, 0);
    do_write(32'hFFFF_FFFF, 0, 0);   // R4 raw bit 21 still differs from stored 0
    do_write(32'h0, 1, 1);

    // R6 R7 R8: every cpl x feature x strobe pattern
    for (int c = 0; c < 4; c++)
      for (int fu = 0; fu < 2; fu++)
        for (int op = 0; op < 4; op++) begin
          logic legal, exp_ill;
          cpl = c[1:0]; feat_uap = fu[0];
          ac_clr = op[0]; ac_set = op[1];
          legal = fu[0] && c == 0 && (op == 1 || op == 2);
          exp_ill = (op != 0) && !legal;
          step();
          if (legal) m_ac = (op == 2);
          chk(ac_flag == m_ac, "R6/R7/R8 ac flag", ac_flag, m_ac);
          chk(illegal_op == exp_ill, "R7/R8 illegal", illegal_op, exp_ill);
          step();
          chk(!illegal_op, "R7 illegal one cycle", illegal_op, 0);
        end

    // R10: write and legal set in the same cycle
    cpl = 0; feat_uap = 1; feat_sse = 1;
    ac_clr = 1; step(); m_ac = 0;
    cr_wr_en = 1; cr_wr_data = 32'h0020_0000; ac_set = 1;
    step(); m_cr = 32'h0020_0000; m_ac = 1;
    chk(cr_value == m_cr && ac_flag == 1, "R10 both applied",
        {cr_value[30:0], ac_flag}, {m_cr[30:0], 1'b1});

    // R9: mode sweep over cpl x uap x ac
    for (int u = 0; u < 2; u++)
      for (int a = 0; a < 2; a++) begin
        cpl = 0; feat_uap = 1; feat_sse = 1;
        cr_wr_en = 1; cr_wr_data = u[0] ? 32'h0020_0000 : 32'h0;
        if (a == 1) ac_set = 1; else ac_clr = 1;
        step();
        for (int c = 0; c < 4; c++) begin
          logic [1:0] em;
          cpl = c[1:0];
          #1;
          em = (c == 3) ? 2'd1 : (u == 1 && a == 1) ? 2'd2 : 2'd0;
          chk(mode_idx == em, "R9 mode index", mode_idx, em);
        end
      end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule